// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a single-port synchronous memory whose bus never needs an idle cycle between a read and a write. Every command is captured on a rising clock edge. A write's data follows its address by one edge in flow-through mode, or by two edges in pipelined mode. Read data returns with the same offset: one edge in flow-through mode and two edges in pipelined mode. Because both paths lag by the same amount, reads and writes can alternate on every clock and the shared data bus stays fully used. A static mode pin selects between the two timings, and the mode is only changed while the block is held in reset.

A load cycle starts an access at a full address. Later cycles can advance a four-beat burst internally, stepping the low two address bits either linearly or by an XOR pattern. Three chip-select inputs must all be high for a load to be accepted. A sleep input stops new accesses. An output-enable input gates the read bus asynchronously. A read always sees the newest issued write to its word, even if that write's data has not yet reached the array.

The data path has fixed timing and accepts at most one command per clock. There is no ready signal and no back-pressure: a source can never be stalled, and it must present each write's data on the edge its mode dictates. `rdata_drive` acts as the valid flag for the read stream and is high only on the edge where a read result is presented.

Top module: `lw_sram`

## Requirements
- R1: A load cycle (`adv`=0) is accepted only when `ce_a`, `ce_b` and `ce_c` are all 1 and `sleep` is 0. Otherwise no read result appears, no write takes place, and any burst in progress ends.
- R2: With `pipe_mode`=0, the result of a read accepted at edge N is visible after edge N. With `pipe_mode`=1, it is visible after edge N+1. It stays visible for one cycle, with `rdata_drive`=1.
- R3: For a write accepted at edge N, `wdata` is taken at edge N+1 when `pipe_mode`=0 and at edge N+2 when `pipe_mode`=1.
- R4: Bit i of `byte_en` covers data bits [9i+8:9i]. Bytes whose bit is 0 keep their stored value. `byte_en` is sampled on every accepted beat.
- R5: A read returns the newest issued writes to its word, merged byte by byte over the stored contents, even if their data arrives after the read was accepted.
- R6: With `interleave`=0 (sampled at load), beat k of a burst (k counted from 0 at the load) uses low address bits (start+k) mod 4. The upper address bits are those of the load.
- R7: With `interleave`=1, beat k uses low address bits start XOR (k mod 4). The read or write direction of every beat is the one given at the load.
- R8: When `oe`=0, `rdata` is 0 and `rdata_drive` is 0 at once, without waiting for a clock edge. Raising `oe` shows a pending result at once.
- R9: `sleep`=1 blocks loads and advances and ends the current burst. Writes already accepted still complete.
- R10: Deselected cycles keep the late-write stages moving, so a write followed by idle cycles still lands in the array.
- R11: While `rst_n`=0 and after reset, `rdata_drive` is 0 and `rdata` is 0 until a read result is due.
- R12: An advance cycle (`adv`=1) with no burst in progress performs no access. Chip selects and `we` are ignored on advance cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| pipe_mode | input | 1 | 1 selects pipelined timing, 0 selects flow-through; static |
| ce_a | input | 1 | Chip select, active high |
| ce_b | input | 1 | Chip select, active high |
| ce_c | input | 1 | Chip select, active high |
| sleep | input | 1 | Blocks new accesses and ends bursts |
| adv | input | 1 | 0 loads a new address, 1 advances the current burst |
| interleave | input | 1 | Burst order at load: 0 linear, 1 XOR |
| we | input | 1 | Write (1) or read (0), sampled at load |
| byte_en | input | BYTES | Per-byte write enables |
| addr | input | ADDR_W | Word address at load |
| wdata | input | DATA_W | Late write data |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | DATA_W | Read data, 0 when not driven |
| rdata_drive | output | 1 | Read data is valid and driven |

## Verification
On every cycle, the embedded properties check that a deselected or sleeping load yields no command. They also check that a read result in either mode raises the drive flag on the edge its latency calls for, that a flow-through write cycle never drives the bus, that bursts keep their upper address bits, and that sleep ends a burst. Only the bench scenarios can show that the stored data is right. This covers the full-array sweep, byte merging, forwarding of data still in flight across back-to-back read/write mixes, both burst orders from every start offset, and the asynchronous effect of `oe`.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} burst_ord_e;

  // Low address bits for a given beat of a four-beat burst.
  function automatic logic [BEAT_W-1:0] beat_offset(input logic [BEAT_W-1:0] start,
                                                    input logic [BEAT_W-1:0] beat,
                                                    input burst_ord_e        ord);
    logic [BEAT_W-1:0] r;
    if (ord == ORD_XOR) r = start ^ beat;
    else                r = start + beat;
    return r;
  endfunction
endpackage

// File: rtl/lw_burst_gen.sv
module lw_burst_gen
  import lw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_all,
  input  logic              sleep,
  input  logic              adv,
  input  logic              interleave,
  input  logic              we,
  input  logic [BYTES-1:0]  byte_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BYTES-1:0]  cmd_be
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              act_q;
  logic              wr_q;
  burst_ord_e        ord_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_n;
  logic              load;
  logic              cont;

  always_comb begin
    load     = !adv && ce_all && !sleep;
    cont     = adv && act_q && !sleep;
    beat_n   = beat_q + 1'b1;
    cmd_vld  = load || cont;
    cmd_wr   = load ? we : wr_q;
    cmd_be   = byte_en;
    if (load) cmd_addr = addr;
    else      cmd_addr = {base_q[ADDR_W-1 -: HI_W], beat_offset(base_q[BEAT_W-1:0], beat_n, ord_q)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ord_q  <= ORD_LINEAR;
      base_q <= '0;
      beat_q <= '0;
    end else if (sleep) begin
      act_q <= 1'b0;
    end else if (!adv) begin
      act_q  <= ce_all;
      beat_q <= '0;
      if (ce_all) begin
        base_q <= addr;
        wr_q   <= we;
        ord_q  <= burst_ord_e'(interleave);
      end
    end else if (act_q) begin
      beat_q <= beat_n;
    end
  end

  // R9: a sleep cycle leaves no burst to advance
  p_sleep_ends_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !act_q);
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] stored;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  // The write that commits on this edge is folded into a read on the same edge.
  always_comb begin
    stored = mem[rd_addr];
    for (int b = 0; b < BYTES; b++) begin
      if (wr_en && wr_be[b] && (wr_addr == rd_addr))
        rd_word[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
      else
        rd_word[b*BYTE_W +: BYTE_W] = stored[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/lw_read_out.sv
module lw_read_out #(
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              ld_vld,
  input  logic [DATA_W-1:0] ld_word,
  input  logic              patch_en,
  input  logic [BYTES-1:0]  patch_be,
  input  logic [DATA_W-1:0] patch_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive
);
  logic              r1_vld, r1_patch, r2_vld;
  logic [BYTES-1:0]  r1_pbe;
  logic [DATA_W-1:0] r1_dat, r2_dat, patched, sel_dat;
  logic              sel_vld;

  // A write accepted one edge before the read gets its data on the next edge.
  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      if (r1_patch && r1_pbe[b]) patched[b*BYTE_W +: BYTE_W] = patch_data[b*BYTE_W +: BYTE_W];
      else                       patched[b*BYTE_W +: BYTE_W] = r1_dat[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1_vld   <= 1'b0;
      r1_patch <= 1'b0;
      r1_pbe   <= '0;
      r1_dat   <= '0;
      r2_vld   <= 1'b0;
      r2_dat   <= '0;
    end else begin
      r1_vld   <= ld_vld;
      r1_patch <= ld_vld && patch_en;
      r1_pbe   <= patch_be;
      r1_dat   <= ld_word;
      r2_vld   <= pipe_mode && r1_vld;
      r2_dat   <= patched;
    end
  end

  always_comb begin
    sel_vld     = pipe_mode ? r2_vld : r1_vld;
    sel_dat     = pipe_mode ? r2_dat : r1_dat;
    rdata_drive = oe && sel_vld;
    rdata       = rdata_drive ? sel_dat : '0;
  end

  // R2: the second output stage stays empty in flow-through mode
  p_flow_no_stage2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode |=> !r2_vld);
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              ce_a,
  input  logic              ce_b,
  input  logic              ce_c,
  input  logic              sleep,
  input  logic              adv,
  input  logic              interleave,
  input  logic              we,
  input  logic [BYTES-1:0]  byte_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive
);
  logic              cmd_vld, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BYTES-1:0]  cmd_be;
  logic              s1_vld, s1_wr, s2_vld, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_be, s2_be;
  logic              wr_en, patch_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTES-1:0]  wr_be;
  logic [DATA_W-1:0] rd_word;

  lw_burst_gen #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
    .clk(clk), .rst_n(rst_n), .ce_all(ce_a && ce_b && ce_c), .sleep(sleep),
    .adv(adv), .interleave(interleave), .we(we), .byte_en(byte_en), .addr(addr),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be)
  );

  // Late-write stages: s1 holds the command of the previous edge, s2 the one before.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0; s1_be <= '0;
      s2_vld <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_be <= '0;
    end else begin
      s1_vld <= cmd_vld; s1_wr <= cmd_wr; s1_addr <= cmd_addr; s1_be <= cmd_be;
      s2_vld <= s1_vld;  s2_wr <= s1_wr;  s2_addr <= s1_addr;  s2_be <= s1_be;
    end
  end

  always_comb begin
    if (pipe_mode) begin
      wr_en = s2_vld && s2_wr; wr_addr = s2_addr; wr_be = s2_be;
    end else begin
      wr_en = s1_vld && s1_wr; wr_addr = s1_addr; wr_be = s1_be;
    end
    patch_en = pipe_mode && s1_vld && s1_wr && (s1_addr == cmd_addr);
  end

  lw_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wdata),
    .rd_addr(cmd_addr), .rd_word(rd_word)
  );

  lw_read_out #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe),
    .ld_vld(cmd_vld && !cmd_wr), .ld_word(rd_word),
    .patch_en(patch_en), .patch_be(s1_be), .patch_data(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  // R1: a load without all three selects produces no command
  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !(ce_a && ce_b && ce_c)) |=> !s1_vld);
  // R9: sleep blocks every access
  p_sleep_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_vld);
  // R2: flow-through read is presented right after its edge
  p_flow_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && s1_vld && !s1_wr && oe) |-> rdata_drive);
  // R2: pipelined read is presented one edge later
  p_pipe_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && s2_vld && !s2_wr && oe) |-> rdata_drive);
  // R3: a flow-through write cycle never drives the read bus
  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && s1_vld && s1_wr) |-> !rdata_drive);
  // R6: burst beats keep the upper address bits of the load
  p_burst_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sleep && s1_vld) |=> (s1_vld && s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));
endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 6, NB = 2, BW = 9, DW = NB * BW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, pipe_mode = 1'b0;
  logic ce_a = 1'b0, ce_b = 1'b0, ce_c = 1'b0, sleep = 1'b0, adv = 1'b0;
  logic interleave = 1'b0, we = 1'b0, oe = 1'b1;
  logic [NB-1:0] byte_en = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_drive;

  lw_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
    .sleep(sleep), .adv(adv), .interleave(interleave), .we(we), .byte_en(byte_en),
    .addr(addr), .wdata(wdata), .oe(oe), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, lat = 1;
  string cur_req = "R11";
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] due0 = '0, due1 = '0, due2 = '0, cd0 = '0, cd1 = '0, last_d = '0;
  logic cv0 = 1'b0, cv1 = 1'b0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [NB-1:0] be);
    logic [DW-1:0] r = o;
    for (int b = 0; b < NB; b++) if (be[b]) r[b*BW +: BW] = n[b*BW +: BW];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 2731 + salt * 977 + 5) ^ (a << 9));
  endfunction

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: pins as given, plus what the bench expects the block to do.
  task automatic tick(input logic a_adv, input logic [2:0] a_ce, input logic a_we,
                      input logic [AW-1:0] a_addr, input logic [NB-1:0] a_be,
                      input logic [DW-1:0] a_wd, input logic a_sleep,
                      input logic e_v, input logic e_wr, input logic [AW-1:0] e_addr);
    @(negedge clk);
    adv = a_adv; {ce_a, ce_b, ce_c} = a_ce; we = a_we; addr = a_addr;
    byte_en = a_be; sleep = a_sleep; wdata = due0;
    if (e_v && e_wr) begin
      ref_mem[e_addr] = merge(ref_mem[e_addr], a_wd, a_be);
      if (lat == 1) due1 = a_wd; else due2 = a_wd;
    end
    if (e_v && !e_wr) begin
      if (lat == 1) begin cv0 = 1'b1; cd0 = ref_mem[e_addr]; end
      else          begin cv1 = 1'b1; cd1 = ref_mem[e_addr]; end
    end
    @(posedge clk); #1;
    last_d = cd0;
    if (cv0 && oe) chk(cur_req, {rdata_drive, rdata}, {1'b1, cd0});
    else           chk(cur_req, {rdata_drive, rdata}, {1'b0, {DW{1'b0}}});
    cv0 = cv1; cd0 = cd1; cv1 = 1'b0; cd1 = '0;
    due0 = due1; due1 = due2; due2 = '0;
  endtask

  task automatic wr1(input int a, input logic [NB-1:0] be, input logic [DW-1:0] d);
    tick(1'b0, 3'b111, 1'b1, AW'(a), be, d, 1'b0, 1'b1, 1'b1, AW'(a));
  endtask
  task automatic rd1(input int a);
    tick(1'b0, 3'b111, 1'b0, AW'(a), '0, '0, 1'b0, 1'b1, 1'b0, AW'(a));
  endtask
  task automatic idle();
    tick(1'b0, 3'b011, 1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      pipe_mode = m[0]; lat = m + 1; rst_n = 1'b0; oe = 1'b1;
      cv0 = 0; cv1 = 0; due0 = '0; due1 = '0; due2 = '0;
      repeat (3) @(posedge clk);
      #1 cur_req = "R11"; chk("R11", {rdata_drive, rdata}, '0);
      @(negedge clk) rst_n = 1'b1;
      idle();
      // R3 write sweep then R2 read sweep over the whole array
      cur_req = "R3"; for (int a = 0; a < DEPTH; a++) wr1(a, 2'b11, pat(a, m));
      cur_req = "R2"; for (int a = 0; a < DEPTH; a++) rd1(a);
      idle(); idle();
      // R4 / R5 byte merge with back-to-back write/read and double writes
      cur_req = "R4";
      for (int a = 0; a < 8; a++)
        for (int be = 0; be < 4; be++) begin wr1(a, NB'(be), pat(a, be + 7)); rd1(a); end
      cur_req = "R5";
      for (int a = 8; a < 16; a++) begin
        wr1(a, 2'b01, pat(a, 40)); wr1(a, 2'b10, pat(a, 41)); rd1(a); wr1(a + 1, 2'b11, pat(a, 42)); rd1(a + 1); rd1(a);
      end
      // R1: every non-all select pattern blocks a write
      cur_req = "R1";
      for (int c = 0; c < 7; c++) begin
        tick(1'b0, 3'(c), 1'b1, 6'd5, 2'b11, pat(c, 90), 1'b0, 1'b0, 1'b0, '0);
        tick(1'b0, 3'(c), 1'b0, 6'd5, '0, '0, 1'b0, 1'b0, 1'b0, '0);
        idle(); rd1(5);
      end
      // R6 / R7: read bursts and write bursts, both orders, every start offset
      for (int o = 0; o < 2; o++) begin
        interleave = o[0];
        cur_req = (o == 0) ? "R6" : "R7";
        for (int s = 0; s < 4; s++) begin
          tick(1'b0, 3'b111, 1'b0, AW'(16 + s), '0, '0, 1'b0, 1'b1, 1'b0, AW'(16 + s));
          for (int k = 1; k < 6; k++) begin
            automatic int lo = (o == 0) ? ((s + k) % 4) : (s ^ (k % 4));
            tick(1'b1, 3'b000, 1'b1, 6'd63, '0, '0, 1'b0, 1'b1, 1'b0, AW'(16 + lo));
          end
          tick(1'b0, 3'b111, 1'b1, AW'(24 + s), 2'b11, pat(s, 60 + o), 1'b0, 1'b1, 1'b1, AW'(24 + s));
          for (int k = 1; k < 4; k++) begin
            automatic int lo = (o == 0) ? ((s + k) % 4) : (s ^ k);
            tick(1'b1, 3'b000, 1'b0, 6'd0, NB'(k), pat(k, 70 + s), 1'b0, 1'b1, 1'b1, AW'(24 + lo));
          end
          for (int k = 0; k < 4; k++) rd1(24 + k);
        end
      end
      interleave = 1'b0;
      // R12: advance with no burst does nothing, even with write asserted
      cur_req = "R12";
      idle();
      tick(1'b1, 3'b111, 1'b1, 6'd33, 2'b11, pat(1, 80), 1'b0, 1'b0, 1'b0, '0);
      tick(1'b1, 3'b111, 1'b0, 6'd33, '0, '0, 1'b0, 1'b0, 1'b0, '0);
      idle(); rd1(33); rd1(34);
      // R9: sleep blocks loads and bursts; a prior write still lands
      cur_req = "R9";
      wr1(20, 2'b11, pat(20, 91));
      tick(1'b0, 3'b111, 1'b1, 6'd21, 2'b11, pat(21, 92), 1'b1, 1'b0, 1'b0, '0);
      tick(1'b1, 3'b111, 1'b0, 6'd21, '0, '0, 1'b1, 1'b0, 1'b0, '0);
      idle(); rd1(20); rd1(21);
      rd1(40);
      tick(1'b1, 3'b111, 1'b0, 6'd0, '0, '0, 1'b1, 1'b0, 1'b0, '0);
      tick(1'b1, 3'b111, 1'b0, 6'd0, '0, '0, 1'b0, 1'b0, 1'b0, '0);
      idle();
      // R10: deselected cycles after a write
      cur_req = "R10";
      wr1(30, 2'b11, pat(30, 93)); idle(); idle(); idle(); rd1(30);
      idle(); idle();
      // R8: output enable acts without a clock
      cur_req = "R8";
      oe = 1'b0; rd1(45);
      if (lat == 2) idle();
      oe = 1'b1; #1;
      chk("R8", {rdata_drive, rdata}, {1'b1, last_d});
      oe = 1'b0; #1;
      chk("R8", {rdata_drive, rdata}, '0);
      oe = 1'b1;
      idle(); idle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule